// File: doc/BRIEF.md
# Decimal Readout Digit Multiplexer

This block sits between an eight-decade decimal count and a character display that is scanned one column at a time. The count arrives as eight BCD digits in parallel. Digit 0 is the fast, least significant decade and digit 7 is the most significant. A carry out of the top decade is also supplied. An external scan sequencer places a column index on the select input, and the block answers on a shared 4-bit bus with the code for that column and a blank indicator. The digit-to-character conversion further down the line is outside this block.

Two display rules are applied inside the multiplexer. Leading zeros are suppressed, so the display never shows zeros to the left of the first significant digit. A latched overflow flag replaces the leftmost column with a "greater than" marker. The overflow flag is the only state in the block. The carry sets it, and a synchronous clear or reset drops it. Everything else is combinational from the current digits, the flag and the select input.

Top module: `readout_mux`

## Requirements
- R1: After reset the overflow flag is clear, so with every digit at 9 the leftmost column (index 7) shows code 9.
- R2: A high `carry_in` at a clock edge, with `clr` low, sets the overflow flag. The flag stays set through later edges where `carry_in` is low, until `clr` or `rst`.
- R3: A high `clr` at a clock edge clears the overflow flag. It also wins over a `carry_in` that is high in the same edge.
- R4: For an index `sel` in 0..7 that is neither blanked nor overridden, `bus_code` equals digit `sel` (bits 4*sel+3..4*sel of `digits`) and `blank` is 0.
- R5: A column at index 1..7 is blanked when its own digit and every more significant digit are zero. A blanked column drives `bus_code` = 4'hF with `blank` = 1.
- R6: Column 0 is never blanked, so an all-zero count shows code 0 at index 0 with `blank` = 0.
- R7: While the overflow flag is set, index 7 drives `bus_code` = 4'hE with `blank` = 0, whatever digit 7 holds.
- R8: The blanking of indices 0..6 depends only on the digit values, and is the same with the overflow flag set or clear.
- R9: An index `sel` of 8..15 drives `bus_code` = 4'hF with `blank` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the overflow flag |
| carry_in | input | 1 | Carry out of the most significant decade |
| digits | input | 32 | Eight BCD digits, digit i in bits 4i+3..4i |
| sel | input | 4 | Column index from the scan sequencer |
| bus_code | output | 4 | Code for the selected column |
| blank | output | 1 | High when the selected column is blanked |

## Verification
The bench sweeps every column index over a set of counts whose first significant digit sits at each position, with the overflow flag both clear and set. It then compares every column against a model built from powers of ten. One design fault blanks column 0 on a zero count and so shows an empty display. Another takes the overflow marker into account when scanning for zeros, so counts like 3 under overflow lose their blanking. The bench also drives a carry and a clear in the same edge, which catches a flag whose priority is inverted. Out-of-range indices are checked so that a design which wraps the index onto a real digit shows up.

// File: rtl/readout_pkg.sv
package readout_pkg;

    localparam int unsigned DIGIT_W      = 4;
    localparam int unsigned DEF_N_DIG    = 8;
    localparam int unsigned DEF_SEL_W    = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    localparam digit_t CODE_BLANK = 4'hF;
    localparam digit_t CODE_OVER  = 4'hE;

    typedef enum logic [1:0] {
        COL_DIGIT,
        COL_BLANK,
        COL_OVER
    } col_kind_e;

    typedef struct packed {
        digit_t code;
        logic   blank;
    } bus_word_t;

    function automatic bus_word_t word_for(col_kind_e kind, digit_t d);
        bus_word_t w;
        case (kind)
            COL_OVER:  begin w.code = CODE_OVER;  w.blank = 1'b0; end
            COL_BLANK: begin w.code = CODE_BLANK; w.blank = 1'b1; end
            default:   begin w.code = d;          w.blank = 1'b0; end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/readout_ovf_latch.sv
module readout_ovf_latch (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic carry_in,
    output logic ovf
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            ovf <= 1'b0;
        else if (carry_in)
            ovf <= 1'b1;
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        (carry_in && !clr) |=> ovf);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);

    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> !ovf);

endmodule

// File: rtl/readout_zero_scan.sv
module readout_zero_scan
    import readout_pkg::*;
#(
    parameter int unsigned N_DIG = DEF_N_DIG
) (
    input  logic                    clk,
    input  logic                    rst,
    input  digit_t [N_DIG-1:0]      digs,
    output logic   [N_DIG-1:0]      lead_mask
);

    logic [N_DIG:0] zero_above;

    assign zero_above[N_DIG] = 1'b1;

    for (genvar i = 0; i < N_DIG; i++) begin : g_col
        assign zero_above[i] = zero_above[i+1] && (digs[i] == '0);
        if (i == 0) begin : g_lsd
            assign lead_mask[i] = 1'b0;
        end else begin : g_upper
            assign lead_mask[i] = zero_above[i];
        end
    end

    assert_lsd_shown_R6: assert property (@(posedge clk) disable iff (rst)
        !lead_mask[0]);

    assert_top_blank_R5: assert property (@(posedge clk) disable iff (rst)
        (digs[N_DIG-1] != '0) |-> (lead_mask == '0));

endmodule

// File: rtl/readout_digit_mux.sv
module readout_digit_mux
    import readout_pkg::*;
#(
    parameter int unsigned N_DIG = DEF_N_DIG,
    parameter int unsigned SEL_W = DEF_SEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  digit_t [N_DIG-1:0]  digs,
    input  logic   [N_DIG-1:0]  lead_mask,
    input  logic                ovf,
    input  logic   [SEL_W-1:0]  sel,
    output bus_word_t           word
);

    localparam int unsigned IDX_W = (N_DIG > 1) ? $clog2(N_DIG) : 1;
    localparam logic [SEL_W-1:0] LAST = SEL_W'(N_DIG - 1);

    logic             in_range;
    logic [IDX_W-1:0] idx;
    col_kind_e        kind;

    assign in_range = (sel <= LAST);
    assign idx      = sel[IDX_W-1:0];

    always_comb begin
        if (!in_range)
            kind = COL_BLANK;
        else if (ovf && (sel == LAST))
            kind = COL_OVER;
        else if (lead_mask[idx])
            kind = COL_BLANK;
        else
            kind = COL_DIGIT;
        word = word_for(kind, digs[idx]);
    end

    assert_blank_code_R5: assert property (@(posedge clk) disable iff (rst)
        word.blank |-> (word.code == CODE_BLANK));

    assert_range_R9: assert property (@(posedge clk) disable iff (rst)
        (sel > LAST) |-> word.blank);

    assert_marker_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf && sel == LAST) |-> (word.code == CODE_OVER && !word.blank));

    assert_lsd_R6: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> (!word.blank && word.code == digs[0]));

endmodule

// File: rtl/readout_mux.sv
module readout_mux
    import readout_pkg::*;
#(
    parameter int unsigned N_DIG = DEF_N_DIG,
    parameter int unsigned SEL_W = DEF_SEL_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       carry_in,
    input  logic [N_DIG*DIGIT_W-1:0]   digits,
    input  logic [SEL_W-1:0]           sel,
    output logic [DIGIT_W-1:0]         bus_code,
    output logic                       blank
);

    digit_t [N_DIG-1:0] digs;
    logic   [N_DIG-1:0] lead_mask;
    logic               ovf;
    bus_word_t          word;

    assign digs = digits;

    readout_ovf_latch u_ovf (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .carry_in (carry_in),
        .ovf      (ovf)
    );

    readout_zero_scan #(.N_DIG(N_DIG)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .digs      (digs),
        .lead_mask (lead_mask)
    );

    readout_digit_mux #(.N_DIG(N_DIG), .SEL_W(SEL_W)) u_mux (
        .clk       (clk),
        .rst       (rst),
        .digs      (digs),
        .lead_mask (lead_mask),
        .ovf       (ovf),
        .sel       (sel),
        .word      (word)
    );

    assign bus_code = word.code;
    assign blank    = word.blank;

endmodule

// File: tb/readout_mux_tb.sv
module readout_mux_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        clr;
    logic        carry_in;
    logic [31:0] digits;
    logic [3:0]  sel;
    logic [3:0]  bus_code;
    logic        blank;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    readout_mux u_dut (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .carry_in (carry_in),
        .digits   (digits),
        .sel      (sel),
        .bus_code (bus_code),
        .blank    (blank)
    );

    function automatic logic [31:0] to_bcd(longint n);
        logic [31:0] v = '0;
        longint m = n;
        for (int i = 0; i < 8; i++) begin
            v[i*4 +: 4] = 4'(m % 10);
            m = m / 10;
        end
        return v;
    endfunction

    function automatic longint pow10(int e);
        longint p = 1;
        for (int i = 0; i < e; i++) p = p * 10;
        return p;
    endfunction

    task automatic check(string tag, logic [3:0] exp_code, logic exp_blank);
        checks++;
        if (bus_code !== exp_code || blank !== exp_blank) begin
            errors++;
            $display("FAIL %s sel=%0d digits=%h: got code=%h blank=%b, expected code=%h blank=%b",
                     tag, sel, digits, bus_code, blank, exp_code, exp_blank);
        end
    endtask

    task automatic sweep(longint n, bit ovf_on);
        digits = to_bcd(n);
        for (int s = 0; s < 16; s++) begin
            logic [3:0] ec;
            logic       eb;
            string      tag;
            sel = 4'(s);
            #5;
            if (s > 7) begin
                ec = 4'hF; eb = 1'b1; tag = "R9";
            end else if (s == 7 && ovf_on) begin
                ec = 4'hE; eb = 1'b0; tag = "R7";
            end else if (s == 0) begin
                ec = digits[3:0]; eb = 1'b0; tag = "R6";
            end else if (n < pow10(s)) begin
                ec = 4'hF; eb = 1'b1; tag = ovf_on ? "R8" : "R5";
            end else begin
                ec = digits[s*4 +: 4]; eb = 1'b0; tag = ovf_on ? "R8" : "R4";
            end
            check(tag, ec, eb);
        end
    endtask

    longint vals[14] = '{0, 1, 9, 10, 305, 4000, 10001, 700000, 1000500,
                         10000000, 12345678, 99999999, 3, 90000000};

    initial begin
        rst = 1'b1; clr = 1'b0; carry_in = 1'b0;
        digits = '0; sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        digits = to_bcd(99999999);
        sel = 4'd7;
        #5 check("R1", 4'h9, 1'b0);

        // no overflow: full sweep
        foreach (vals[k]) sweep(vals[k], 1'b0);

        // R2: carry sets the flag
        @(negedge clk); carry_in = 1'b1;
        @(negedge clk); carry_in = 1'b0;
        digits = to_bcd(12345678); sel = 4'd7;
        #5 check("R2", 4'hE, 1'b0);
        repeat (4) @(negedge clk);
        #5 check("R2", 4'hE, 1'b0);

        foreach (vals[k]) sweep(vals[k], 1'b1);

        // R3: clear drops the flag
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        digits = to_bcd(12345678); sel = 4'd7;
        #5 check("R3", 4'h1, 1'b0);

        // R3: clear wins over a simultaneous carry
        @(negedge clk); carry_in = 1'b1;
        @(negedge clk); carry_in = 1'b1; clr = 1'b1;
        @(negedge clk); carry_in = 1'b0; clr = 1'b0;
        sel = 4'd7;
        #5 check("R3", 4'h1, 1'b0);

        // R1: reset also clears a set flag
        @(negedge clk); carry_in = 1'b1;
        @(negedge clk); carry_in = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        digits = to_bcd(0); sel = 4'd7;
        #5 check("R1", 4'hF, 1'b1);
        sel = 4'd0;
        #1 check("R6", 4'h0, 1'b0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule